// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block performs the hardware half of taking and leaving an interrupt in a small 16-bit processor model. It holds the stack pointer, instruction pointer, code segment and flag word. Between instructions, the processor core updates these registers through simple write strobes. At an instruction boundary the sequencer looks at a maskable request line. When it takes the request, it saves the running context on a downward-growing stack in memory. It then runs an acknowledge handshake with the interrupt controller to learn the vector number. Next it fetches the handler's segment and offset from a vector table at the bottom of memory, and execution continues at the handler.

A return strobe from the core starts the opposite sequence. Three words are popped back into the instruction pointer, the code segment and the flag word. The flags come back bit for bit, including the interrupt-enable bit. While either sequence runs, a busy output holds off instruction fetch. Memory is reached through one word-wide read/write port. Read data arrives on the cycle after the request.

Top module: `isr_entry_seq`

## Requirements
- R1: A request is sampled only in a cycle where `instr_end` is high while the sequencer is idle. A request held high while `instr_end` is low starts nothing.
- R2: The interrupt-enable bit is bit 9 of the flag word. While it is 0, a request is not taken. In idle, `cli_stb` clears it and `sti_stb` sets it. If both strobes come in the same cycle, the clear wins.
- R3: On entry, three words are written, each to SP-2 after which SP drops by 2. The order is flags, then CS, then IP. SP finishes 6 below its starting value, with IP at SP+0, CS at SP+2 and the saved flags at SP+4. All stack accesses are to even byte addresses.
- R4: Once the three words are saved, `int_ack` is high for exactly one cycle. The sequencer then waits and captures `vec_num` on the first cycle in which `vec_valid` is high.
- R5: The handler IP is the word at byte address vector*4 and the handler CS is the word at vector*4+2. For example, vector 8 reads from 0x20 and 0x22. Read data is taken on the cycle after the read request.
- R6: On `iret_stb`, words are read from SP, SP+2 and SP+4 into IP, CS and flags, with SP rising by 2 after each read. All 16 flag bits are restored exactly.
- R7: On entry, the interrupt-enable bit is cleared as the flag word is saved. The other flag bits are left unchanged, and the stacked copy holds the value from before the clear.
- R8: `busy` is high from the cycle after a sequence starts until it ends. While busy, the core write strobes (`ip_wr`, `cs_wr`, `flags_wr`, `cli_stb`, `sti_stb`) and requests have no effect.
- R9: A synchronous active-high reset sets SP to `SP_INIT` (default 0x0800) and clears IP, CS and flags, so interrupts start disabled. It also clears `busy`, `int_ack` and `mem_req`.
- R10: If `iret_stb` and a request that would be taken fall in the same idle cycle, the return runs and the request is not acknowledged. A later boundary can take the request under the restored flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_end | input | 1 | Last cycle of an instruction (sampling point) |
| intr_req | input | 1 | Maskable interrupt request |
| iret_stb | input | 1 | Start return-from-interrupt |
| cli_stb | input | 1 | Clear interrupt-enable bit |
| sti_stb | input | 1 | Set interrupt-enable bit |
| ip_wr | input | 1 | Core load of IP |
| ip_in | input | DW | IP value from core |
| cs_wr | input | 1 | Core load of CS |
| cs_in | input | DW | CS value from core |
| flags_wr | input | 1 | Core load of flag word |
| flags_in | input | DW | Flag value from core |
| int_ack | output | 1 | One-cycle acknowledge to the controller |
| vec_valid | input | 1 | Vector number is valid |
| vec_num | input | VW | Vector number from the controller |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address (always even) |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, one cycle after request |
| sp_o | output | AW | Stack pointer |
| ip_o | output | DW | Instruction pointer |
| cs_o | output | DW | Code segment |
| flags_o | output | DW | Flag word |
| busy | output | 1 | Sequence in progress, hold fetch |

## Verification
Two functions can land in one cycle. A return strobe and a request that would be accepted can arrive at the same instruction boundary. A core flag or IP update can also arrive while an entry sequence is rewriting those registers. The bench provokes the first case by setting the enable bit inside a handler, then raising `iret_stb`, `instr_end` and `intr_req` together. It judges the result by an unchanged acknowledge count, the restored IP and SP, and a later boundary that does take the request. It provokes the second case by driving `flags_wr`, `sti_stb` and `ip_wr` in the middle of an entry. It then checks that the handler IP and the enable-cleared flags survive.

// File: rtl/isr_seq_pkg.sv
package isr_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_PUSH_FL,
    S_PUSH_CS,
    S_PUSH_IP,
    S_ACK,
    S_WAIT_VEC,
    S_VEC_LO,
    S_VEC_HI,
    S_VEC_END,
    S_POP_IP,
    S_POP_CS,
    S_POP_FL,
    S_POP_END
  } seq_state_t;

  localparam int unsigned WORD_BYTES = 2;
endpackage

// File: rtl/isr_sp_reg.sv
module isr_sp_reg #(
  parameter int AW = 16,
  parameter logic [AW-1:0] SP_INIT = 'h0800
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec,
  input  logic          inc,
  output logic [AW-1:0] sp
);
  localparam logic [AW-1:0] STEP = AW'(isr_seq_pkg::WORD_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= SP_INIT;
    end else if (dec) begin
      sp <= sp - STEP;
    end else if (inc) begin
      sp <= sp + STEP;
    end
  end
endmodule

// File: rtl/isr_ctx_regs.sv
module isr_ctx_regs #(
  parameter int DW     = 16,
  parameter int IF_BIT = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          core_en,
  input  logic          ip_wr,
  input  logic [DW-1:0] ip_in,
  input  logic          cs_wr,
  input  logic [DW-1:0] cs_in,
  input  logic          fl_wr,
  input  logic [DW-1:0] fl_in,
  input  logic          cli,
  input  logic          sti,
  input  logic          ld_ip,
  input  logic          ld_cs,
  input  logic          ld_fl,
  input  logic          clr_if,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] ip,
  output logic [DW-1:0] cs,
  output logic [DW-1:0] flags
);
  logic [DW-1:0] fl_core;

  // core-side flag update: full load first, then enable-bit strobes, clear wins
  always_comb begin
    fl_core = fl_wr ? fl_in : flags;
    if (sti) fl_core[IF_BIT] = 1'b1;
    if (cli) fl_core[IF_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ip    <= '0;
      cs    <= '0;
      flags <= '0;
    end else begin
      if (ld_ip)                 ip <= rdata;
      else if (core_en && ip_wr) ip <= ip_in;

      if (ld_cs)                 cs <= rdata;
      else if (core_en && cs_wr) cs <= cs_in;

      if (ld_fl)        flags         <= rdata;
      else if (clr_if)  flags[IF_BIT] <= 1'b0;
      else if (core_en) flags         <= fl_core;
    end
  end
endmodule

// File: rtl/isr_seq_fsm.sv
module isr_seq_fsm
  import isr_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          instr_end,
  input  logic          intr_req,
  input  logic          iret,
  input  logic          if_flag,
  input  logic          vec_valid,
  input  logic [VW-1:0] vec_num,
  input  logic [AW-1:0] sp,
  input  logic [DW-1:0] ip,
  input  logic [DW-1:0] cs,
  input  logic [DW-1:0] flags,
  output logic          busy,
  output logic          int_ack,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          sp_dec,
  output logic          sp_inc,
  output logic          ld_ip,
  output logic          ld_cs,
  output logic          ld_fl,
  output logic          clr_if
);
  localparam int PAD = AW - VW - 2;
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  seq_state_t state, state_n;
  logic [VW-1:0] vec_q;
  logic [AW-1:0] tbl_base;
  logic [AW-1:0] sp_below;
  logic          accept;

  assign tbl_base = {{PAD{1'b0}}, vec_q, 2'b00};
  assign sp_below = sp - STEP;
  assign accept   = instr_end && intr_req && if_flag;

  always_comb begin
    state_n = state;
    case (state)
      S_IDLE: begin
        if (iret)        state_n = S_POP_IP;
        else if (accept) state_n = S_PUSH_FL;
      end
      S_PUSH_FL:  state_n = S_PUSH_CS;
      S_PUSH_CS:  state_n = S_PUSH_IP;
      S_PUSH_IP:  state_n = S_ACK;
      S_ACK:      state_n = S_WAIT_VEC;
      S_WAIT_VEC: if (vec_valid) state_n = S_VEC_LO;
      S_VEC_LO:   state_n = S_VEC_HI;
      S_VEC_HI:   state_n = S_VEC_END;
      S_VEC_END:  state_n = S_IDLE;
      S_POP_IP:   state_n = S_POP_CS;
      S_POP_CS:   state_n = S_POP_FL;
      S_POP_FL:   state_n = S_POP_END;
      S_POP_END:  state_n = S_IDLE;
      default:    state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      vec_q <= '0;
    end else begin
      state <= state_n;
      if (state == S_WAIT_VEC && vec_valid) vec_q <= vec_num;
    end
  end

  always_comb begin
    busy      = (state != S_IDLE);
    int_ack   = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = sp;
    mem_wdata = flags;
    sp_dec    = 1'b0;
    sp_inc    = 1'b0;
    ld_ip     = 1'b0;
    ld_cs     = 1'b0;
    ld_fl     = 1'b0;
    clr_if    = 1'b0;
    case (state)
      S_PUSH_FL: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp_below;
        mem_wdata = flags; sp_dec = 1'b1; clr_if = 1'b1;
      end
      S_PUSH_CS: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp_below;
        mem_wdata = cs; sp_dec = 1'b1;
      end
      S_PUSH_IP: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp_below;
        mem_wdata = ip; sp_dec = 1'b1;
      end
      S_ACK: int_ack = 1'b1;
      S_VEC_LO: begin
        mem_req = 1'b1; mem_addr = tbl_base;
      end
      S_VEC_HI: begin
        mem_req = 1'b1; mem_addr = tbl_base + STEP; ld_ip = 1'b1;
      end
      S_VEC_END: ld_cs = 1'b1;
      S_POP_IP: begin
        mem_req = 1'b1; mem_addr = sp; sp_inc = 1'b1;
      end
      S_POP_CS: begin
        mem_req = 1'b1; mem_addr = sp; sp_inc = 1'b1; ld_ip = 1'b1;
      end
      S_POP_FL: begin
        mem_req = 1'b1; mem_addr = sp; sp_inc = 1'b1; ld_cs = 1'b1;
      end
      S_POP_END: ld_fl = 1'b1;
      default: ;
    endcase
  end

  // R1: no boundary strobe, no start
  assert_mid_instr_R1: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !instr_end && !iret) |=> !busy);

  // R2: a masked request never starts an entry
  assert_masked_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !if_flag && !iret) |=> !busy);

  // R4: acknowledge is a single-cycle pulse
  assert_ack_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    int_ack |=> !int_ack);

  // R10: a return strobe at idle begins with a stack read, not an acknowledge
  assert_iret_first_R10: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && iret) |=> (mem_req && !mem_we && !int_ack));
endmodule

// File: rtl/isr_entry_seq.sv
module isr_entry_seq #(
  parameter int DW     = 16,
  parameter int AW     = 16,
  parameter int VW     = 8,
  parameter int IF_BIT = 9,
  parameter logic [AW-1:0] SP_INIT = 'h0800
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          instr_end,
  input  logic          intr_req,
  input  logic          iret_stb,
  input  logic          cli_stb,
  input  logic          sti_stb,
  input  logic          ip_wr,
  input  logic [DW-1:0] ip_in,
  input  logic          cs_wr,
  input  logic [DW-1:0] cs_in,
  input  logic          flags_wr,
  input  logic [DW-1:0] flags_in,
  output logic          int_ack,
  input  logic          vec_valid,
  input  logic [VW-1:0] vec_num,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] sp_o,
  output logic [DW-1:0] ip_o,
  output logic [DW-1:0] cs_o,
  output logic [DW-1:0] flags_o,
  output logic          busy
);
  logic sp_dec, sp_inc, ld_ip, ld_cs, ld_fl, clr_if;

  isr_sp_reg #(.AW(AW), .SP_INIT(SP_INIT)) u_sp (
    .clk(clk), .rst(rst), .dec(sp_dec), .inc(sp_inc), .sp(sp_o)
  );

  isr_ctx_regs #(.DW(DW), .IF_BIT(IF_BIT)) u_ctx (
    .clk(clk), .rst(rst), .core_en(!busy),
    .ip_wr(ip_wr), .ip_in(ip_in), .cs_wr(cs_wr), .cs_in(cs_in),
    .fl_wr(flags_wr), .fl_in(flags_in), .cli(cli_stb), .sti(sti_stb),
    .ld_ip(ld_ip), .ld_cs(ld_cs), .ld_fl(ld_fl), .clr_if(clr_if),
    .rdata(mem_rdata), .ip(ip_o), .cs(cs_o), .flags(flags_o)
  );

  isr_seq_fsm #(.DW(DW), .AW(AW), .VW(VW)) u_fsm (
    .clk(clk), .rst(rst), .instr_end(instr_end), .intr_req(intr_req),
    .iret(iret_stb), .if_flag(flags_o[IF_BIT]),
    .vec_valid(vec_valid), .vec_num(vec_num),
    .sp(sp_o), .ip(ip_o), .cs(cs_o), .flags(flags_o),
    .busy(busy), .int_ack(int_ack), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .sp_dec(sp_dec), .sp_inc(sp_inc), .ld_ip(ld_ip), .ld_cs(ld_cs),
    .ld_fl(ld_fl), .clr_if(clr_if)
  );

  // R3: stack and table traffic stays word aligned
  assert_align_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !mem_addr[0]);

  // R7: by the time the controller is acknowledged, interrupts are masked
  assert_masked_at_ack_R7: assert property (@(posedge clk) disable iff (rst)
    int_ack |-> !flags_o[IF_BIT]);

  // R8: the acknowledge only occurs inside a busy sequence
  assert_busy_ack_R8: assert property (@(posedge clk) disable iff (rst)
    int_ack |-> busy);
endmodule

// File: tb/sim_isr_entry_seq.sv
module sim_isr_entry_seq;
  localparam logic [15:0] SP0 = 16'h0800;
  localparam logic [15:0] IFM = 16'h0200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instr_end = 0, intr_req = 0, iret_stb = 0, cli_stb = 0, sti_stb = 0;
  logic ip_wr = 0, cs_wr = 0, flags_wr = 0;
  logic [15:0] ip_in = 0, cs_in = 0, flags_in = 0;
  logic int_ack, vec_valid = 0;
  logic [7:0] vec_num = 0;
  logic mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic [15:0] sp_o, ip_o, cs_o, flags_o;
  logic busy;

  int errors = 0;
  int checks = 0;
  int ack_cnt = 0;
  int pend = 0;
  bit done = 0;

  logic [15:0] mem [1024];
  logic        tb_we = 0;
  logic [15:0] tb_addr = 0, tb_data = 0;

  always #4 clk = ~clk;

  isr_entry_seq u0 (
    .clk(clk), .rst(rst), .instr_end(instr_end), .intr_req(intr_req),
    .iret_stb(iret_stb), .cli_stb(cli_stb), .sti_stb(sti_stb),
    .ip_wr(ip_wr), .ip_in(ip_in), .cs_wr(cs_wr), .cs_in(cs_in),
    .flags_wr(flags_wr), .flags_in(flags_in), .int_ack(int_ack),
    .vec_valid(vec_valid), .vec_num(vec_num), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .sp_o(sp_o), .ip_o(ip_o), .cs_o(cs_o),
    .flags_o(flags_o), .busy(busy)
  );

  // memory model: one-cycle read latency, bench pokes share the port logic
  always @(posedge clk) begin
    if (tb_we) mem[tb_addr[10:1]] <= tb_data;
    else if (mem_req) begin
      if (mem_we) mem[mem_addr[10:1]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[10:1]];
    end
  end

  // controller model: vector valid two cycles after acknowledge
  always @(posedge clk) begin
    if (int_ack) begin
      ack_cnt <= ack_cnt + 1;
      pend    <= 2;
      vec_valid <= 1'b0;
    end else if (pend > 1) begin
      pend <= pend - 1;
      vec_valid <= 1'b0;
    end else if (pend == 1) begin
      pend <= 0;
      vec_valid <= 1'b1;
    end else begin
      vec_valid <= 1'b0;
    end
  end

  // rows: vector, pad, IP, CS, FLAGS (enable bit set in each)
  localparam logic [63:0] ROWS [4] = '{
    {8'h08, 8'h00, 16'h0100, 16'h2000, 16'h0283},
    {8'h00, 8'h00, 16'hABCD, 16'h1234, 16'h0A41},
    {8'hFF, 8'h00, 16'hFFFE, 16'hFFFF, 16'hFFFF},
    {8'h35, 8'h00, 16'h0002, 16'h0000, 16'h0200}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); tb_we = 1; tb_addr = a; tb_data = d;
    @(negedge clk); tb_we = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 200) begin @(negedge clk); n++; end
    if (busy) begin
      errors++; checks++;
      $display("FAIL R8 sequence did not finish actual=busy expected=idle");
    end
  endtask

  task automatic set_ctx(input logic [15:0] i, input logic [15:0] c, input logic [15:0] f);
    @(negedge clk);
    ip_wr = 1; ip_in = i; cs_wr = 1; cs_in = c; flags_wr = 1; flags_in = f;
    @(negedge clk);
    ip_wr = 0; cs_wr = 0; flags_wr = 0;
  endtask

  task automatic raise_irq(input logic [7:0] v);
    vec_num = v;
    @(negedge clk); instr_end = 1; intr_req = 1;
    @(negedge clk); instr_end = 0; intr_req = 0;
  endtask

  task automatic do_iret();
    @(negedge clk); iret_stb = 1;
    @(negedge clk); iret_stb = 0;
    wait_idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    chk("R9 sp", sp_o, SP0);
    chk("R9 flags", flags_o, 16'h0000);
    chk("R9 ip", ip_o, 16'h0000);
    chk("R9 busy", {15'd0, busy}, 16'h0000);
    chk("R9 ack/req", {14'd0, int_ack, mem_req}, 16'h0000);

    // R2 masked request (enable bit 9 clear after reset)
    set_ctx(16'h0300, 16'h0400, 16'h0001);
    raise_irq(8'h08);
    chk("R2 masked busy", {15'd0, busy}, 16'h0000);
    chk("R2 masked ip", ip_o, 16'h0300);

    // R2 clear beats set in the same cycle
    @(negedge clk); cli_stb = 1; sti_stb = 1;
    @(negedge clk); cli_stb = 0; sti_stb = 0;
    chk("R2 cli wins", flags_o, 16'h0001);
    @(negedge clk); sti_stb = 1;
    @(negedge clk); sti_stb = 0;
    chk("R2 sti sets bit9", flags_o, 16'h0201);

    // R1 request without a boundary strobe
    @(negedge clk); intr_req = 1;
    repeat (3) @(negedge clk);
    chk("R1 no boundary busy", {15'd0, busy}, 16'h0000);
    intr_req = 0;

    // table walk: R3 R4 R5 R6 R7
    for (int i = 0; i < 4; i++) begin
      logic [7:0]  v;
      logic [15:0] hip, hcs, oip, ocs, ofl;
      int a0;
      v   = ROWS[i][63:56];
      oip = ROWS[i][47:32];
      ocs = ROWS[i][31:16];
      ofl = ROWS[i][15:0];
      hip = 16'h1000 + 16'(i) * 16'h0111;
      hcs = 16'hC000 + 16'(i);
      poke({6'd0, v, 2'b00}, hip);
      poke({6'd0, v, 2'b00} + 16'd2, hcs);
      set_ctx(oip, ocs, ofl);
      a0 = ack_cnt;
      raise_irq(v);
      chk("R8 busy after accept", {15'd0, busy}, 16'h0001);
      wait_idle();
      chk("R4 one ack", 16'(ack_cnt - a0), 16'd1);
      chk("R5 handler ip", ip_o, hip);
      chk("R5 handler cs", cs_o, hcs);
      chk("R3 sp after entry", sp_o, SP0 - 16'd6);
      chk("R3 ip at +0", mem[sp_o[10:1]], oip);
      chk("R3 cs at +2", mem[sp_o[10:1] + 1], ocs);
      chk("R3 flags at +4", mem[sp_o[10:1] + 2], ofl);
      chk("R7 enable cleared", flags_o, ofl & ~IFM);
      do_iret();
      chk("R6 ip restored", ip_o, oip);
      chk("R6 cs restored", cs_o, ocs);
      chk("R6 flags restored", flags_o, ofl);
      chk("R6 sp restored", sp_o, SP0);
    end

    // R8 core writes during an entry are ignored
    poke(16'h0020, 16'h7000);
    poke(16'h0022, 16'h7100);
    set_ctx(16'h0050, 16'h0060, 16'h0245);
    raise_irq(8'h08);
    flags_wr = 1; flags_in = 16'hFFFF; sti_stb = 1; ip_wr = 1; ip_in = 16'h1234;
    @(negedge clk);
    flags_wr = 0; sti_stb = 0; ip_wr = 0;
    wait_idle();
    chk("R8 ip kept during busy", ip_o, 16'h7000);
    chk("R8 flags kept during busy", flags_o, 16'h0045);

    // R10 return and request at the same boundary; handler re-enabled
    @(negedge clk); sti_stb = 1;
    @(negedge clk); sti_stb = 0;
    begin
      int a1;
      a1 = ack_cnt;
      @(negedge clk); iret_stb = 1; instr_end = 1; intr_req = 1;
      @(negedge clk); iret_stb = 0; instr_end = 0; intr_req = 0;
      wait_idle();
      chk("R10 no ack on return", 16'(ack_cnt - a1), 16'd0);
      chk("R10 ip restored", ip_o, 16'h0050);
      chk("R10 sp restored", sp_o, SP0);
      raise_irq(8'h08);
      chk("R10 later request taken", {15'd0, busy}, 16'h0001);
      wait_idle();
      chk("R10 handler reached", ip_o, 16'h7000);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule